// File: doc/BRIEF.md
# Delta-Sigma Converter Conversion Reader

This block runs a 22-bit delta-sigma analog-to-digital converter in single-shot mode over a three-wire serial link. The converter has a chip select, a serial clock and a data line driven by the converter. A request on `conv_req` starts one conversion. The block drives chip select low for a fixed number of cycles, then releases it. It then waits for a programmable conversion time and clocks out the result frame. The frame's flag bits are decoded into a signed 32-bit value, which is presented for one cycle along with a valid strobe. If the frame is impossible, an error strobe is raised instead.

The serial clock idles at the level chosen by `sclk_idle_hi`. That level is captured when each conversion starts. With an idle-high clock the frame carries 24 data bits. With an idle-low clock the converter first shows a data-ready bit, so the frame is 25 bits long and that extra leading bit is dropped.

A converter that has just left shutdown can fail to wake and answer with all ones. After every reset, the block therefore runs two full conversions back to back and discards both results. Only after that does it accept requests. `busy` covers the whole of that wake-up run and every later conversion.

Top module: `dsadc_reader`

## Requirements
- R1: While reset is applied, and after its release until two complete conversions have run back to back, `busy` is 1. Those two conversions produce exactly two start pulses and two read frames. They raise neither `result_valid` nor `result_err`. A `conv_req` asserted during this period starts nothing once `busy` falls.
- R2: Each conversion begins with `adc_cs_n` held low for exactly START_CYC clock cycles. The first of these is the cycle after the request is sampled.
- R3: After the start pulse, `adc_cs_n` stays high for exactly WAIT_CYC cycles before the read frame begins.
- R4: During the read frame `adc_cs_n` is low. `adc_sclk` gives 24 rising edges when `sclk_idle_hi`=1 and 25 when it is 0. Data is taken MSB first on each rising edge. In the 25-edge case the first bit is a data-ready flag and is discarded. While `adc_cs_n` is high, `adc_sclk` rests at the captured idle level.
- R5: Number the aligned 24-bit word bit 23 (underrange flag), bit 22 (overrange flag), bit 21 (sign) down to bit 0. With bits 23, 22 and 21 all zero, `result` is the word zero-extended.
- R6: With bit 22 clear and either bit 23 or bit 21 set, `result` is bits 21..0 of the word with bits 31..22 all ones.
- R7: With bit 22 set and bit 23 clear, `result` is bits 21..0 of the word with bits 31..22 all zero, so it stays positive even if bit 21 is set.
- R8: With bits 23 and 22 both set, `result_err` pulses for one cycle, `result_valid` stays 0 and `result` keeps its previous value.
- R9: `result_valid` (or `result_err`) is high for exactly one cycle, in the first cycle in which `busy` is 0 after a conversion. `busy` is 1 from the cycle after the request is sampled until then.
- R10: `conv_req` asserted while `busy` is 1 is ignored: no further conversion follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_req | input | 1 | Start one conversion when idle |
| sclk_idle_hi | input | 1 | Serial clock idle level, captured at each conversion start |
| busy | output | 1 | Wake-up run or conversion in progress |
| result | output | 32 | Last valid signed result |
| result_valid | output | 1 | One-cycle strobe: `result` updated |
| result_err | output | 1 | One-cycle strobe: both range flags set, no value |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_miso | input | 1 | Serial data from the converter |

## Verification
Counted from the clock edge that samples a request, `adc_cs_n` is low for START_CYC cycles, then high for WAIT_CYC cycles. The read frame then lasts SCLK_HALF_CYC*(1+2N) cycles, where N is 24 or 25. The strobe follows two edges after the frame's last high phase ends, in the same cycle `busy` drops. The bench samples every output on the falling clock edge. In each task it measures the low and high windows of chip select and the rising serial-clock edges cycle by cycle. It checks the result and both strobes in the cycle the first strobe appears, and checks that both strobes are gone one cycle later. For the wake-up run and for the ignored request, it watches chip select and `busy` over a fixed quiet window.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  // Width of the aligned converter word and of the signed result.
  localparam int WORD_W = 24;
  localparam int RES_W  = 32;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_READ,
    ST_FIN
  } ctrl_state_t;

  typedef enum logic [1:0] {
    PH_LEAD,
    PH_LOW,
    PH_HIGH
  } sclk_phase_t;

endpackage

// File: rtl/dsadc_decode.sv
module dsadc_decode #(
  parameter int WORD_W = 24,
  parameter int RES_W  = 32
) (
  input  logic [WORD_W-1:0] word,
  output logic [RES_W-1:0]  value,
  output logic              both_flags
);

  localparam int MAG_W = WORD_W - 2;
  localparam int EXT_W = RES_W - MAG_W;

  logic flag_under;
  logic flag_over;
  logic sign_bit;

  always_comb begin
    flag_under = word[WORD_W-1];
    flag_over  = word[WORD_W-2];
    sign_bit   = word[WORD_W-3];
    both_flags = flag_under & flag_over;
    if (flag_over) begin
      // above full scale: drop the flag, keep the magnitude positive
      value = {{EXT_W{1'b0}}, word[MAG_W-1:0]};
    end else if (flag_under | sign_bit) begin
      value = {{EXT_W{1'b1}}, word[MAG_W-1:0]};
    end else begin
      value = {{EXT_W{1'b0}}, word[MAG_W-1:0]};
    end
  end

endmodule

// File: rtl/dsadc_spi_rx.sv
module dsadc_spi_rx
  import dsadc_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int WORD_W   = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              idle_hi,
  input  logic              miso,
  output logic              sclk,
  output logic              done,
  output logic [WORD_W-1:0] word
);

  localparam int HC_W = $clog2(HALF_CYC + 1);
  localparam int BC_W = $clog2(WORD_W + 1);
  localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

  logic              active_q, active_d;
  sclk_phase_t       phase_q, phase_d;
  logic [HC_W-1:0]   hc_q, hc_d;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              sh_en;
  logic              sclk_q, sclk_d;
  logic              done_q, done_d;
  logic [BC_W-1:0]   last_bit;

  // idle-low framing carries one leading data-ready bit
  assign last_bit = idle_hi ? BC_W'(WORD_W - 1) : BC_W'(WORD_W);

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    hc_d     = hc_q;
    bc_d     = bc_q;
    sclk_d   = sclk_q;
    done_d   = 1'b0;
    sh_en    = 1'b0;
    sh_d     = {sh_q[WORD_W-2:0], miso};
    if (start) begin
      active_d = 1'b1;
      phase_d  = PH_LEAD;
      hc_d     = '0;
      bc_d     = '0;
      sclk_d   = idle_hi;
    end else if (active_q) begin
      if (hc_q == HC_LAST) begin
        hc_d = '0;
        case (phase_q)
          PH_LEAD: begin
            phase_d = PH_LOW;
            sclk_d  = 1'b0;
          end
          PH_LOW: begin
            phase_d = PH_HIGH;
            sclk_d  = 1'b1;
            sh_en   = 1'b1;
          end
          PH_HIGH: begin
            if (bc_q == last_bit) begin
              active_d = 1'b0;
              done_d   = 1'b1;
              sclk_d   = idle_hi;
            end else begin
              bc_d    = bc_q + 1'b1;
              phase_d = PH_LOW;
              sclk_d  = 1'b0;
            end
          end
          default: begin
            phase_d = PH_LEAD;
          end
        endcase
      end else begin
        hc_d = hc_q + 1'b1;
      end
    end else begin
      sclk_d = idle_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= PH_LEAD;
      hc_q     <= '0;
      bc_q     <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      sh_q     <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      hc_q     <= hc_d;
      bc_q     <= bc_d;
      sclk_q   <= sclk_d;
      done_q   <= done_d;
      if (sh_en) begin
        sh_q <= sh_d;
      end
    end
  end

  assign sclk = sclk_q;
  assign done = done_q;
  assign word = sh_q;

  AST_SPI_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R4
  AST_SPI_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active_q); // R4
  AST_SPI_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> bc_q <= BC_W'(WORD_W)); // R4

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int START_CYC = 2000,
  parameter int WAIT_CYC  = 20751563,
  parameter int WAKE_CONV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic idle_hi_in,
  input  logic spi_done,
  output logic spi_start,
  output logic cpol,
  output logic cs_n,
  output logic busy,
  output logic waking,
  output logic report
);

  localparam int CNT_MAX = (START_CYC > WAIT_CYC) ? START_CYC : WAIT_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int WK_W    = $clog2(WAKE_CONV + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(START_CYC - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(WAIT_CYC - 1);
  localparam logic [WK_W-1:0]  WK_INIT    = WK_W'(WAKE_CONV);

  ctrl_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic [WK_W-1:0]  wake_q, wake_d;
  logic             cpol_q, cpol_d;
  logic             cs_n_q, cs_n_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q + 1'b1;
    cnt_en    = 1'b0;
    wake_d    = wake_q;
    cpol_d    = cpol_q;
    spi_start = 1'b0;
    case (state_q)
      ST_BOOT: begin
        cnt_en = 1'b1;
        cnt_d  = '0;
        cpol_d = idle_hi_in;
        state_d = (wake_q != '0) ? ST_PULSE : ST_IDLE;
      end
      ST_IDLE: begin
        if (req) begin
          state_d = ST_PULSE;
          cnt_en  = 1'b1;
          cnt_d   = '0;
          cpol_d  = idle_hi_in;
        end
      end
      ST_PULSE: begin
        cnt_en = 1'b1;
        if (cnt_q == PULSE_LAST) begin
          state_d = ST_WAIT;
          cnt_d   = '0;
        end
      end
      ST_WAIT: begin
        cnt_en = 1'b1;
        if (cnt_q == WAIT_LAST) begin
          state_d   = ST_READ;
          cnt_d     = '0;
          spi_start = 1'b1;
        end
      end
      ST_READ: begin
        if (spi_done) begin
          state_d = ST_FIN;
        end
      end
      ST_FIN: begin
        if (wake_q == '0) begin
          state_d = ST_IDLE;
        end else if (wake_q == WK_W'(1)) begin
          wake_d  = '0;
          state_d = ST_IDLE;
        end else begin
          // next wake conversion follows with no idle gap
          wake_d  = wake_q - 1'b1;
          state_d = ST_PULSE;
          cnt_en  = 1'b1;
          cnt_d   = '0;
          cpol_d  = idle_hi_in;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
    cs_n_d = !((state_d == ST_PULSE) || (state_d == ST_READ));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      cnt_q   <= '0;
      wake_q  <= WK_INIT;
      cpol_q  <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      wake_q  <= wake_d;
      cpol_q  <= cpol_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign cpol   = cpol_q;
  assign cs_n   = cs_n_q;
  assign busy   = (state_q != ST_IDLE);
  assign waking = (wake_q != '0);
  assign report = (state_q == ST_FIN) && (wake_q == '0);

  AST_PULSE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PULSE) |-> (cnt_q <= PULSE_LAST)); // R2
  AST_WAIT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (cnt_q <= WAIT_LAST)); // R3
  AST_CS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> busy); // R9
  AST_DONE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    spi_done |-> (state_q == ST_READ)); // R4
  AST_WAKE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    !waking |=> !waking); // R1

endmodule

// File: rtl/dsadc_reader.sv
module dsadc_reader
  import dsadc_pkg::*;
#(
  parameter int START_CYC      = 2000,
  parameter int WAIT_CYC       = 20751563,
  parameter int SCLK_HALF_CYC  = 4,
  parameter int WAKE_CONV      = 2,
  parameter int RST_STAGES     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_req,
  input  logic             sclk_idle_hi,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             result_err,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  input  logic             adc_miso
);

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[RST_STAGES-1];

  logic              spi_start;
  logic              spi_done;
  logic              cpol;
  logic              waking;
  logic              report;
  logic [WORD_W-1:0] raw_word;
  logic [RES_W-1:0]  dec_value;
  logic              dec_err;

  dsadc_ctrl #(
    .START_CYC (START_CYC),
    .WAIT_CYC  (WAIT_CYC),
    .WAKE_CONV (WAKE_CONV)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .req        (conv_req),
    .idle_hi_in (sclk_idle_hi),
    .spi_done   (spi_done),
    .spi_start  (spi_start),
    .cpol       (cpol),
    .cs_n       (adc_cs_n),
    .busy       (busy),
    .waking     (waking),
    .report     (report)
  );

  dsadc_spi_rx #(
    .HALF_CYC (SCLK_HALF_CYC),
    .WORD_W   (WORD_W)
  ) i_spi_rx (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (spi_start),
    .idle_hi (cpol),
    .miso    (adc_miso),
    .sclk    (adc_sclk),
    .done    (spi_done),
    .word    (raw_word)
  );

  dsadc_decode #(
    .WORD_W (WORD_W),
    .RES_W  (RES_W)
  ) i_decode (
    .word       (raw_word),
    .value      (dec_value),
    .both_flags (dec_err)
  );

  logic [RES_W-1:0] result_q;
  logic             res_en;
  logic             valid_q, valid_d;
  logic             err_q, err_d;

  always_comb begin
    res_en  = report && !dec_err;
    valid_d = report && !dec_err;
    err_d   = report && dec_err;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_q <= '0;
      valid_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (res_en) begin
        result_q <= dec_value;
      end
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign result       = result_q;
  assign result_valid = valid_q;
  assign result_err   = err_q;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(valid_q && err_q)); // R8
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    valid_q |=> !valid_q); // R9
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_q |=> !err_q); // R8
  AST_STROBE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (valid_q || err_q) |-> !busy); // R9
  AST_WAKE_SILENT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    waking |-> (!valid_q && !err_q)); // R1
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adc_cs_n |-> (adc_sclk == cpol)); // R4
  AST_RESULT_HOLD_ON_ERR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_q |-> $stable(result_q)); // R8

endmodule

// File: tb/test_dsadc_reader.sv
`timescale 1ns/1ps
module test_dsadc_reader;

  localparam int P = 6;
  localparam int W = 20;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        conv_req = 1'b0;
  logic        cpol_drv = 1'b1;
  logic        busy;
  logic [31:0] result;
  logic        result_valid;
  logic        result_err;
  logic        adc_cs_n;
  logic        adc_sclk;
  logic        adc_miso;

  logic        slv_dr = 1'b0;
  logic [23:0] slv_word = 24'hFFFFFF;
  int          idx = 0;
  int          n_chk = 0;
  int          n_err = 0;

  always #2 clk = ~clk;

  dsadc_reader #(
    .START_CYC     (P),
    .WAIT_CYC      (W),
    .SCLK_HALF_CYC (H)
  ) i_dsadc_reader (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_req     (conv_req),
    .sclk_idle_hi (cpol_drv),
    .busy         (busy),
    .result       (result),
    .result_valid (result_valid),
    .result_err   (result_err),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .adc_miso     (adc_miso)
  );

  // converter model: frame bit presented at select fall and advanced on clock falls
  function automatic logic pick(int i, logic c, logic dr, logic [23:0] w);
    logic [24:0] f;
    int nb;
    f  = {dr, w};
    nb = c ? 24 : 25;
    if (i >= 0 && i < nb) return f[nb-1-i];
    return 1'b1;
  endfunction

  assign adc_miso = pick(idx, cpol_drv, slv_dr, slv_word);

  always @(negedge adc_cs_n) idx = cpol_drv ? -1 : 0;
  always @(negedge adc_sclk) if (!adc_cs_n) idx = idx + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic t_wake();
    int cyc = 0;
    int falls = 0;
    int pulses = 0;
    logic pcs = 1'b1;
    bit quiet = 1'b1;
    cpol_drv = 1'b1;
    slv_word = 24'hFFFFFF;
    #1 rst_n = 1'b0;
    conv_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy && adc_cs_n && !result_valid && !result_err, "R1 reset state",
        {28'd0, busy, adc_cs_n, result_valid, result_err}, 32'hC);
    rst_n = 1'b1;
    while (cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 10) conv_req = 1'b0;
      if (!adc_cs_n && pcs) falls++;
      pcs = adc_cs_n;
      if (result_valid || result_err) pulses++;
      if (!busy) break;
    end
    chk(cyc < 5000, "R1 wake run ends", 32'(cyc), 32'd0);
    chk(falls == 4, "R1 two pulses and two frames", 32'(falls), 32'd4);
    chk(pulses == 0, "R1 no strobe during wake", 32'(pulses), 32'd0);
    repeat (30) begin
      @(negedge clk);
      if (!adc_cs_n || busy || result_valid || result_err) quiet = 1'b0;
    end
    chk(quiet, "R1 request during wake ignored", {31'd0, quiet}, 32'd1);
  endtask

  task automatic run_conv(input logic cp, input logic dr, input logic [23:0] w,
                          input bit exp_e, input logic [31:0] exp_v,
                          input string tag, input bit poke);
    int pl = 0;
    int gap = 0;
    int rises = 0;
    int seg = 0;
    int cyc = 0;
    logic ps;
    logic [31:0] prev;
    bit got_v = 1'b0;
    bit got_e = 1'b0;
    bit busy_at = 1'b1;
    bit quiet = 1'b1;
    @(negedge clk);
    cpol_drv = cp;
    slv_dr   = dr;
    slv_word = w;
    prev     = result;
    ps       = adc_sclk;
    conv_req = 1'b1;
    while (cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) conv_req = 1'b0;
      if (poke && cyc == 8) conv_req = 1'b1;
      if (poke && cyc == 9) conv_req = 1'b0;
      if (seg == 0) begin
        if (!adc_cs_n) pl++;
        else begin seg = 1; gap = 1; end
      end else if (seg == 1) begin
        if (adc_cs_n) gap++;
        else seg = 2;
      end else if (seg == 2) begin
        if (adc_cs_n) seg = 3;
      end
      if (seg == 2 && adc_sclk && !ps) rises++;
      ps = adc_sclk;
      if (result_valid || result_err) begin
        got_v   = result_valid;
        got_e   = result_err;
        busy_at = busy;
        break;
      end
    end
    chk(cyc < 4000, {tag, " R9 conversion completes"}, 32'(cyc), 32'd0);
    chk(pl == P, {tag, " R2 start pulse width"}, 32'(pl), 32'(P));
    chk(gap == W, {tag, " R3 conversion wait"}, 32'(gap), 32'(W));
    chk(rises == (cp ? 24 : 25), {tag, " R4 frame clock edges"}, 32'(rises), cp ? 32'd24 : 32'd25);
    chk(!busy_at, {tag, " R9 busy low with strobe"}, {31'd0, busy_at}, 32'd0);
    chk(got_e == exp_e && got_v == !exp_e, {tag, " strobe kind"},
        {30'd0, got_e, got_v}, {30'd0, exp_e, !exp_e});
    chk(result == (exp_e ? prev : exp_v), {tag, " result value"}, result, exp_e ? prev : exp_v);
    @(negedge clk);
    chk(!result_valid && !result_err, {tag, " R9 one-cycle strobe"},
        {30'd0, result_err, result_valid}, 32'd0);
    if (poke) begin
      repeat (30) begin
        @(negedge clk);
        if (!adc_cs_n || busy) quiet = 1'b0;
      end
      chk(quiet, {tag, " R10 request while busy ignored"}, {31'd0, quiet}, 32'd1);
    end
  endtask

  initial begin
    t_wake();
    run_conv(1'b1, 1'b0, 24'h000001, 1'b0, 32'h00000001, "R5 positive idle-high", 1'b0);
    run_conv(1'b0, 1'b1, 24'h1ABCDE, 1'b0, 32'h001ABCDE, "R4 R5 data-ready dropped", 1'b0);
    run_conv(1'b1, 1'b0, 24'h200000, 1'b0, 32'hFFE00000, "R6 negative in range", 1'b0);
    run_conv(1'b0, 1'b0, 24'h3FFFFF, 1'b0, 32'hFFFFFFFF, "R6 minus one", 1'b0);
    run_conv(1'b1, 1'b0, 24'h800000, 1'b0, 32'hFFC00000, "R6 underrange", 1'b0);
    run_conv(1'b0, 1'b1, 24'h9FFFFF, 1'b0, 32'hFFDFFFFF, "R6 underrange idle-low", 1'b0);
    run_conv(1'b1, 1'b0, 24'h400005, 1'b0, 32'h00000005, "R7 overrange", 1'b0);
    run_conv(1'b0, 1'b0, 24'h600000, 1'b0, 32'h00200000, "R7 overrange over sign", 1'b0);
    run_conv(1'b1, 1'b0, 24'hC00000, 1'b1, 32'h0, "R8 both flags", 1'b0);
    run_conv(1'b0, 1'b0, 24'hFFFFFF, 1'b1, 32'h0, "R8 all ones", 1'b0);
    run_conv(1'b1, 1'b0, 24'h0A5A5A, 1'b0, 32'h000A5A5A, "R10 poke", 1'b1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule